// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block makes the bit clock and the frame sync for a PCM voice port when the port is the timing master, and passes the clock and sync of an outside source through when it is not. The whole block runs on one system clock. A one-cycle enable tick at 4 MHz, supplied from outside, is the timing reference for the fixed-rate path.

The bit clock comes from one phase accumulator that is fed in one of two ways. On the fixed path the accumulator steps only on reference ticks and gives a 128, 256 or 512 kHz bit clock with an 8 kHz frame. On the programmable path it steps on every system clock with a software-chosen rate and limit, and the frame length in bit clocks comes from a divider field. The frame sync is either a long pulse that rises at the frame start or a one-bit pulse whose falling edge marks the frame start. It can also be held low while the clock keeps running.

All configuration inputs are sampled into shadow registers once after reset and after that only at a frame boundary. A frame boundary is the bit-clock rising edge at which the frame counter wraps to zero. Because of this, a change never cuts a clock or sync pulse short.

Top module: `pcm_clkgen`

## Requirements
- R1: While reset is low, `bclk_o`, `fsync_o`, `bclk_oe` and `fsync_oe` are all 0, even when the external clock and sync inputs are high.
- R2: On the fixed path (`cfg_dds_sel`=0), `cfg_rate_sel` 2'b01 gives 16 bit clocks per frame, 2'b00 gives 32, 2'b10 gives 64, and the unused code 2'b11 behaves as 2'b00. Every frame lasts exactly 500 reference ticks. The generated clock changes only in cycles that follow a `ref_tick` pulse.
- R3: On the programmable path (`cfg_dds_sel`=1), each system clock adds `cfg_dds_step` to an accumulator. When the sum reaches or passes `cfg_dds_limit`, the limit is subtracted and the bit clock toggles. Over a frame of N bit clocks, the cycle count times the step is within one limit plus one step of 2·N·limit. This requires 0 < step < limit.
- R4: On the programmable path, a frame holds `cfg_sync_div` bit clocks. Values 0 and 1 are treated as 2.
- R5: A long sync (`cfg_short_sync`=0) rises together with the bit-clock rising edge that starts a frame. It stays high for 8 bit clocks, or for 16 when `cfg_long16`=1 on the programmable path; the fixed path ignores `cfg_long16`. If the frame has no more bit clocks than the pulse length, the pulse ends one bit clock before the next frame.
- R6: A short sync (`cfg_short_sync`=1) is high for exactly one bit clock, the last one of each frame. It falls on the bit-clock rising edge at the frame boundary.
- R7: While the generated signals drive the outputs, `fsync_o` changes only in the same cycle as a rising edge of `bclk_o`.
- R8: With `cfg_sync_mute`=1 and generated timing selected, `fsync_o` stays 0 while `bclk_o` keeps toggling.
- R9: With `cfg_slave`=1 and `cfg_dds_sel`=0, `bclk_o` and `fsync_o` equal `ext_bclk` and `ext_fsync` in the same cycle, and both output enables are 0.
- R10: With `cfg_dds_sel`=1, both output enables are 0 whatever the value of `cfg_slave`, and the generated clock and sync appear on `bclk_o` and `fsync_o`.
- R11: As master on the fixed path, both output enables are 1.
- R12: The shadowed configuration changes only in the first cycle after reset or at a frame boundary. A change made in the middle of a frame leaves the rest of that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle 4 MHz reference enable |
| cfg_slave | input | 1 | 1: take clock and sync from outside |
| cfg_dds_sel | input | 1 | 1: programmable accumulator path |
| cfg_rate_sel | input | 2 | Fixed-path bit clock rate code |
| cfg_short_sync | input | 1 | 1: one-bit sync ending at frame start |
| cfg_long16 | input | 1 | 1: 16-bit long sync (programmable path) |
| cfg_sync_mute | input | 1 | 1: hold sync low, clock keeps running |
| cfg_dds_limit | input | LIM_W | Accumulator limit |
| cfg_dds_step | input | RATE_W | Accumulator step per system clock |
| cfg_sync_div | input | DIV_W | Bit clocks per frame (programmable path) |
| ext_bclk | input | 1 | External bit clock |
| ext_fsync | input | 1 | External frame sync |
| bclk_o | output | 1 | Bit clock out |
| fsync_o | output | 1 | Frame sync out |
| bclk_oe | output | 1 | Drive enable for the bit clock pin |
| fsync_oe | output | 1 | Drive enable for the sync pin |

## Verification
The assertions assume that `ref_tick` is a single-cycle pulse, that the programmable step is non-zero and below the limit, and that configuration inputs change only away from the clock edge. The stimulus keeps to these limits. It produces the tick from a fixed 12-cycle counter and draws random steps from 16 to 255 with a limit of two to seven steps. It drives all inputs on the falling clock edge. Random frame lengths stay above 16, so a random long pulse is never clipped. The clipping cases are covered by directed tests.

// File: rtl/pcm_clkgen_pkg.sv
// Package: shared types for the PCM clock and sync generator.
// Assumes: nothing beyond IEEE 1800-2017.
package pcm_clkgen_pkg;

    // Fixed-path rate codes; the encoding matches the configuration field.
    typedef enum logic [1:0] {
        RATE_256  = 2'b00,
        RATE_128  = 2'b01,
        RATE_512  = 2'b10,
        RATE_RSVD = 2'b11
    } rate_e;

    // Mode bits held in the shadow register.
    typedef struct packed {
        logic  slave;
        logic  dds;
        rate_e rate;
        logic  short_fs;
        logic  len16;
        logic  mute;
    } mode_t;

endpackage

// File: rtl/pcm_cfg_shadow.sv
// Module: pcm_cfg_shadow
// Holds the active configuration. Loads the incoming fields only when
// load is high. Flags when the incoming fields differ from the held ones.
// Assumes: load is asserted only at frame boundaries or once after reset.
module pcm_cfg_shadow
    import pcm_clkgen_pkg::*;
#(
    parameter int LIM_W  = 13,
    parameter int RATE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  mode_t             mode_in,
    input  logic [LIM_W-1:0]  lim_in,
    input  logic [RATE_W-1:0] step_in,
    input  logic [DIV_W-1:0]  div_in,
    output mode_t             mode_q,
    output logic [LIM_W-1:0]  lim_q,
    output logic [RATE_W-1:0] step_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              changed
);

    // Capture the configuration on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            lim_q  <= '0;
            step_q <= '0;
            div_q  <= '0;
        end else if (load) begin
            mode_q <= mode_in;
            lim_q  <= lim_in;
            step_q <= step_in;
            div_q  <= div_in;
        end
    end

    // Flag a pending difference between incoming and held fields.
    always_comb begin
        changed = (mode_in != mode_q) || (lim_in != lim_q) ||
                  (step_in != step_q) || (div_in != div_q);
    end

endmodule

// File: rtl/pcm_nco.sv
// Module: pcm_nco
// Phase accumulator that toggles the bit clock each time the sum reaches
// the limit. Reports the cycle in which a rising toggle takes place.
// Assumes: 0 < step < limit while en is high.
module pcm_nco #(
    parameter int ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [ACC_W-1:0] limit,
    input  logic [ACC_W-1:0] step,
    output logic             bclk_q,
    output logic             rise
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   rem;
    logic             hit;

    // Next accumulator value and the crossing test.
    always_comb begin
        sum  = {1'b0, acc} + {1'b0, step};
        rem  = sum - {1'b0, limit};
        hit  = en && (sum >= {1'b0, limit});
        rise = hit && !bclk_q;
    end

    // Advance the phase and toggle the clock; clr drops the phase but keeps the toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            bclk_q <= 1'b0;
        end else begin
            if (clr) begin
                acc <= '0;
            end else if (en) begin
                acc <= hit ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
            end
            if (hit) begin
                bclk_q <= !bclk_q;
            end
        end
    end

endmodule

// File: rtl/pcm_frame_seq.sv
// Module: pcm_frame_seq
// Counts bit-clock rising edges within a frame, flags the wrap, and
// updates the registered sync on each rising edge.
// Assumes: len_act and len_eff are at least 2; the wrap uses the active
// length, the sync uses the length in force after the edge.
module pcm_frame_seq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [CNT_W-1:0] len_act,
    input  logic [CNT_W-1:0] len_eff,
    input  logic [CNT_W-1:0] slen_eff,
    input  logic             short_eff,
    input  logic             mute_eff,
    output logic             wrap,
    output logic             fsync_q
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_n;
    logic             fs_n;

    // Next count and the sync level it implies.
    always_comb begin
        wrap  = rise && (cnt >= len_act - CNT_W'(1));
        cnt_n = wrap ? '0 : (rise ? cnt + CNT_W'(1) : cnt);
        if (mute_eff) begin
            fs_n = 1'b0;
        end else if (short_eff) begin
            fs_n = (cnt_n == len_eff - CNT_W'(1));
        end else begin
            fs_n = (cnt_n < slen_eff) && (cnt_n != len_eff - CNT_W'(1));
        end
    end

    // Frame position; the reset value makes the first rising edge a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
        end else begin
            cnt <= cnt_n;
        end
    end

    // Sync register, updated only on bit-clock rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_q <= 1'b0;
        end else if (rise) begin
            fsync_q <= fs_n;
        end
    end

endmodule

// File: rtl/pcm_clkgen.sv
// Module: pcm_clkgen (top)
// Generates the PCM bit clock and frame sync from either a fixed-rate path
// (stepped by a 4 MHz tick) or a programmable accumulator. Passes external
// timing through in slave mode. Configuration is shadowed per frame.
// Assumes: ref_tick is a one-cycle pulse; programmable step below limit.
module pcm_clkgen
    import pcm_clkgen_pkg::*;
#(
    parameter int LIM_W         = 13,
    parameter int RATE_W        = 8,
    parameter int DIV_W         = 8,
    parameter int FIX_LIMIT     = 4000,
    parameter int FIX_BASE_STEP = 256,
    parameter int FIX_BASE_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              cfg_slave,
    input  logic              cfg_dds_sel,
    input  logic [1:0]        cfg_rate_sel,
    input  logic              cfg_short_sync,
    input  logic              cfg_long16,
    input  logic              cfg_sync_mute,
    input  logic [LIM_W-1:0]  cfg_dds_limit,
    input  logic [RATE_W-1:0] cfg_dds_step,
    input  logic [DIV_W-1:0]  cfg_sync_div,
    input  logic              ext_bclk,
    input  logic              ext_fsync,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic              bclk_oe,
    output logic              fsync_oe
);

    localparam int ACC_W = LIM_W + 1;
    localparam int CNT_W = (DIV_W > 7) ? DIV_W : 7;

    mode_t             mode_in;
    mode_t             mode_a;
    logic [LIM_W-1:0]  lim_a;
    logic [RATE_W-1:0] step_a;
    logic [DIV_W-1:0]  div_a;
    logic              cfg_changed;
    logic              primed;
    logic              load;
    logic              wrap;
    logic              gen_bclk;
    logic              gen_fsync;
    logic              gen_rise;
    logic              nco_en;
    logic [ACC_W-1:0]  nco_lim;
    logic [ACC_W-1:0]  nco_step;
    logic [CNT_W-1:0]  len_act;
    logic [CNT_W-1:0]  len_eff;
    logic [CNT_W-1:0]  slen_eff;
    logic              short_eff;
    logic              mute_eff;
    logic              pass_ext;

    // Bit clocks per frame for a given path, rate code and divider.
    function automatic logic [CNT_W-1:0] frame_len(input logic dds,
                                                   input rate_e r,
                                                   input logic [DIV_W-1:0] d);
        if (dds) begin
            frame_len = (d < DIV_W'(2)) ? CNT_W'(2) : CNT_W'(d);
        end else begin
            case (r)
                RATE_128: frame_len = CNT_W'(FIX_BASE_BITS);
                RATE_512: frame_len = CNT_W'(FIX_BASE_BITS * 4);
                default:  frame_len = CNT_W'(FIX_BASE_BITS * 2);
            endcase
        end
    endfunction

    // Accumulator step per reference tick on the fixed path.
    function automatic logic [ACC_W-1:0] fix_step(input rate_e r);
        case (r)
            RATE_128: fix_step = ACC_W'(FIX_BASE_STEP);
            RATE_512: fix_step = ACC_W'(FIX_BASE_STEP * 4);
            default:  fix_step = ACC_W'(FIX_BASE_STEP * 2);
        endcase
    endfunction

    // Long sync length in bit clocks.
    function automatic logic [CNT_W-1:0] sync_len(input logic dds, input logic l16);
        sync_len = (dds && l16) ? CNT_W'(16) : CNT_W'(8);
    endfunction

    // Pack the incoming mode bits.
    always_comb begin
        mode_in = '{slave: cfg_slave, dds: cfg_dds_sel,
                    rate: rate_e'(cfg_rate_sel), short_fs: cfg_short_sync,
                    len16: cfg_long16, mute: cfg_sync_mute};
    end

    // One-shot flag that marks the first configuration load after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
    end

    assign load = !primed || wrap;

    pcm_cfg_shadow #(
        .LIM_W (LIM_W),
        .RATE_W(RATE_W),
        .DIV_W (DIV_W)
    ) shadow_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .mode_in(mode_in),
        .lim_in (cfg_dds_limit),
        .step_in(cfg_dds_step),
        .div_in (cfg_sync_div),
        .mode_q (mode_a),
        .lim_q  (lim_a),
        .step_q (step_a),
        .div_q  (div_a),
        .changed(cfg_changed)
    );

    // Feed the shared accumulator from the active path.
    always_comb begin
        nco_en   = primed && (mode_a.dds || ref_tick);
        nco_lim  = mode_a.dds ? ACC_W'(lim_a)  : ACC_W'(FIX_LIMIT);
        nco_step = mode_a.dds ? ACC_W'(step_a) : fix_step(mode_a.rate);
    end

    pcm_nco #(
        .ACC_W(ACC_W)
    ) nco_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (nco_en),
        .clr   (load && cfg_changed),
        .limit (nco_lim),
        .step  (nco_step),
        .bclk_q(gen_bclk),
        .rise  (gen_rise)
    );

    // Frame settings: active ones for the wrap, next ones for the sync.
    always_comb begin
        len_act   = frame_len(mode_a.dds, mode_a.rate, div_a);
        len_eff   = load ? frame_len(cfg_dds_sel, rate_e'(cfg_rate_sel), cfg_sync_div) : len_act;
        slen_eff  = load ? sync_len(cfg_dds_sel, cfg_long16) : sync_len(mode_a.dds, mode_a.len16);
        short_eff = load ? cfg_short_sync : mode_a.short_fs;
        mute_eff  = load ? cfg_sync_mute  : mode_a.mute;
    end

    pcm_frame_seq #(
        .CNT_W(CNT_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (gen_rise),
        .len_act  (len_act),
        .len_eff  (len_eff),
        .slen_eff (slen_eff),
        .short_eff(short_eff),
        .mute_eff (mute_eff),
        .wrap     (wrap),
        .fsync_q  (gen_fsync)
    );

    // Output select and pin drive enables.
    always_comb begin
        pass_ext = mode_a.slave && !mode_a.dds;
        bclk_o   = pass_ext ? ext_bclk  : gen_bclk;
        fsync_o  = pass_ext ? ext_fsync : gen_fsync;
        bclk_oe  = primed && !mode_a.slave && !mode_a.dds;
        fsync_oe = primed && !mode_a.slave && !mode_a.dds;
    end

endmodule

// File: rtl/pcm_clkgen_chk.sv
// Module: pcm_clkgen_chk
// Temporal checks on the generator, bound to every pcm_clkgen instance.
// Assumes: ref_tick is a single-cycle pulse.
module pcm_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic       bclk_o,
    input logic       fsync_o,
    input logic       bclk_oe,
    input logic       bclk_q,
    input logic       wrap,
    input logic       primed,
    input logic [6:0] mode_bits
);

    logic dds_a;
    logic mute_a;
    assign dds_a  = mode_bits[5];
    assign mute_a = mode_bits[0];

    // R7: a driven sync only moves on a bit-clock rising edge.
    assert_sync_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_oe && $past(bclk_oe) && !$stable(fsync_o)) |-> $rose(bclk_o));

    // R8: muted sync stays low while the pins are driven.
    assert_mute_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_oe && mute_a) |-> !fsync_o);

    // R10: the programmable path never drives the pins.
    assert_dds_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dds_a |-> !bclk_oe);

    // R12: the held mode changes only after a frame boundary.
    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !wrap) |=> $stable(mode_bits));

    // R2: on the fixed path the clock steps only on reference ticks.
    assert_fixed_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dds_a && !ref_tick) |=> $stable(bclk_q));

endmodule

bind pcm_clkgen pcm_clkgen_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .bclk_o   (bclk_o),
    .fsync_o  (fsync_o),
    .bclk_oe  (bclk_oe),
    .bclk_q   (gen_bclk),
    .wrap     (wrap),
    .primed   (primed),
    .mode_bits(mode_a)
);

// File: tb/pcm_clkgen_tb_top.sv
`timescale 1ns/1ps
module pcm_clkgen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       cfg_slave = 1'b0;
    logic       cfg_dds_sel = 1'b0;
    logic [1:0] cfg_rate_sel = 2'b01;
    logic       cfg_short_sync = 1'b0;
    logic       cfg_long16 = 1'b1;
    logic       cfg_sync_mute = 1'b0;
    logic [12:0] cfg_dds_limit = 13'd300;
    logic [7:0] cfg_dds_step = 8'd100;
    logic [7:0] cfg_sync_div = 8'd20;
    logic       ext_bclk = 1'b1;
    logic       ext_fsync = 1'b1;
    logic       bclk_o, fsync_o, bclk_oe, fsync_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcm_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .cfg_slave(cfg_slave), .cfg_dds_sel(cfg_dds_sel),
        .cfg_rate_sel(cfg_rate_sel), .cfg_short_sync(cfg_short_sync),
        .cfg_long16(cfg_long16), .cfg_sync_mute(cfg_sync_mute),
        .cfg_dds_limit(cfg_dds_limit), .cfg_dds_step(cfg_dds_step),
        .cfg_sync_div(cfg_sync_div), .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
        .bclk_o(bclk_o), .fsync_o(fsync_o), .bclk_oe(bclk_oe), .fsync_oe(fsync_oe)
    );

    // 4 MHz reference: one pulse every 12 system clocks.
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div <= (tick_div == 11) ? 0 : tick_div + 1;
        ref_tick <= (tick_div == 11);
    end

    // Output monitor, sampled on the falling edge.
    logic prev_b = 1'b0, prev_f = 1'b0, prev_oe = 1'b0;
    bit   align_on = 1'b0;
    int   cyc = 0, rise_total = 0, fs_rises = 0;
    int   rise_at_fs = 0, cyc_at_fs = 0, hi_cnt = 0;
    int   last_rises = 0, last_cyc = 0, last_width = 0, misalign = 0;
    bit   fall_on_b = 1'b0;
    always @(negedge clk) begin
        bit brise;
        brise = bclk_o && !prev_b;
        cyc++;
        if (rst_n) begin
            if (brise) rise_total++;
            if (fsync_o && !prev_f) begin
                fs_rises++;
                last_rises = rise_total - rise_at_fs;
                rise_at_fs = rise_total;
                last_cyc   = cyc - cyc_at_fs;
                cyc_at_fs  = cyc;
                hi_cnt     = 0;
            end
            if (brise && fsync_o) hi_cnt++;
            if (!fsync_o && prev_f) begin
                last_width = hi_cnt;
                fall_on_b  = brise;
            end
            if ((fsync_o != prev_f) && !brise && ((bclk_oe && prev_oe) || align_on))
                misalign++;
        end
        prev_b  = bclk_o;
        prev_f  = fsync_o;
        prev_oe = bclk_oe;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fs(input int n);
        int target;
        target = fs_rises + n;
        while (fs_rises < target) @(posedge clk);
        #1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_width(input bit dds, input bit shrt, input bit l16, input int n);
        int w;
        if (shrt) return 1;
        w = (dds && l16) ? 16 : 8;
        return (w >= n) ? n - 1 : w;
    endfunction

    task automatic fixed_case(input logic [1:0] code, input int bits);
        @(negedge clk);
        cfg_rate_sel = code;
        wait_fs(3);
        chk(last_rises == bits, "R2 bits per frame", last_rises, bits);
        chk(last_cyc == 6000, "R2 frame of 500 ticks", last_cyc, 6000);
        chk(last_width == 8, "R5 fixed long width", last_width, 8);
        chk(bclk_oe && fsync_oe, "R11 master enables", bclk_oe, 1);
    endtask

    task automatic dds_case(input int step, input int lim, input int dv, input bit shrt, input bit l16);
        int n;
        longint err;
        @(negedge clk);
        cfg_dds_step = 8'(step);
        cfg_dds_limit = 13'(lim);
        cfg_sync_div = 8'(dv);
        cfg_short_sync = shrt;
        cfg_long16 = l16;
        wait_fs(3);
        n = (dv < 2) ? 2 : dv;
        chk(last_rises == n, "R4 frame length", last_rises, n);
        err = longint'(last_cyc) * step - 2 * longint'(n) * lim;
        if (err < 0) err = -err;
        chk(err <= lim + step, "R3 accumulator rate", last_cyc, 2 * n * lim / step);
        chk(last_width == exp_width(1'b1, shrt, l16, n),
            shrt ? "R6 short width" : "R5 long width", last_width, exp_width(1'b1, shrt, l16, n));
        if (shrt) chk(fall_on_b, "R6 fall on boundary edge", fall_on_b, 1);
        chk(!bclk_oe && !fsync_oe, "R10 enables off", bclk_oe, 0);
    endtask

    // Main sequence.
    initial begin
        int r_before, f_before;
        void'($urandom(32'h5eed_0c11));
        wait_cyc(5);
        chk(!bclk_o && !fsync_o && !bclk_oe && !fsync_oe, "R1 reset outputs",
            {bclk_o, fsync_o, bclk_oe, fsync_oe}, 0);
        rst_n = 1'b1;

        // Fixed path: all rate codes; cfg_long16 is set but must be ignored.
        fixed_case(2'b01, 16);
        fixed_case(2'b10, 64);
        fixed_case(2'b00, 32);
        fixed_case(2'b11, 32);

        // Programmable path, directed corners.
        @(negedge clk);
        cfg_dds_sel = 1'b1;
        dds_case(100, 300, 20, 1'b0, 1'b1);
        align_on = 1'b1;
        dds_case(100, 300, 10, 1'b0, 1'b1);
        dds_case(100, 300, 1, 1'b0, 1'b1);
        dds_case(100, 300, 0, 1'b0, 1'b0);
        dds_case(100, 300, 12, 1'b1, 1'b0);

        // R12: a change inside a frame waits for the boundary.
        dds_case(100, 300, 20, 1'b0, 1'b0);
        wait_cyc(5);
        cfg_sync_div = 8'd30;
        wait_fs(1);
        chk(last_rises == 20, "R12 frame in progress keeps length", last_rises, 20);
        wait_fs(1);
        chk(last_rises == 30, "R12 new length after boundary", last_rises, 30);

        // Constrained random programmable configurations.
        for (int i = 0; i < 8; i++) begin
            int st, lm, dv;
            st = 16 + int'($urandom % 240);
            lm = st * (2 + int'($urandom % 6)) + int'($urandom % st);
            dv = 17 + int'($urandom % 24);
            dds_case(st, lm, dv, 1'($urandom), 1'($urandom));
        end

        // R8: sync held low while the clock runs.
        dds_case(100, 300, 20, 1'b0, 1'b0);
        @(negedge clk);
        cfg_sync_mute = 1'b1;
        wait_cyc(300);
        r_before = rise_total;
        f_before = fs_rises;
        wait_cyc(300);
        chk(fs_rises == f_before && !fsync_o, "R8 sync held low", fs_rises - f_before, 0);
        chk(rise_total - r_before >= 40, "R8 clock keeps running", rise_total - r_before, 50);
        @(negedge clk);
        cfg_sync_mute = 1'b0;
        align_on = 1'b0;

        // R9: slave pass-through.
        cfg_slave = 1'b1;
        cfg_dds_sel = 1'b0;
        cfg_rate_sel = 2'b10;
        wait_cyc(300);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ext_bclk = 1'($urandom);
            ext_fsync = 1'($urandom);
            #1;
            chk(bclk_o == ext_bclk && fsync_o == ext_fsync, "R9 pass-through",
                {bclk_o, fsync_o}, {ext_bclk, ext_fsync});
            chk(!bclk_oe && !fsync_oe, "R9 enables off", {bclk_oe, fsync_oe}, 0);
        end

        // R10: programmable path overrides the slave bit.
        @(negedge clk);
        ext_bclk = 1'b0;
        ext_fsync = 1'b0;
        cfg_dds_sel = 1'b1;
        wait_cyc(6500);
        r_before = rise_total;
        wait_cyc(200);
        chk(rise_total - r_before >= 20, "R10 generated clock on output", rise_total - r_before, 33);
        chk(!bclk_oe && !fsync_oe, "R10 enables off with slave bit", {bclk_oe, fsync_oe}, 0);

        chk(misalign == 0, "R7 sync moves with clock rise", misalign, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule